// File: doc/BRIEF.md
# Scatter-Gather DMA Status Register

This block holds the status word of a scatter-gather DMA engine. The descriptor-processing engine sends it single-cycle event pulses when:

- a streaming-side error is seen,
- a transfer is cut short by an end-of-packet marker,
- a descriptor finishes,
- the whole descriptor chain finishes.

Each pulse sets a sticky flag. The flag stays set until software writes a 1 to its bit position.

Alongside the sticky flags the block derives a read-only BUSY flag from the engine's run control bit and its stop-on-error control bit. BUSY rises one cycle after run goes high. It stays up while descriptors are in flight. It drops in one of two cases:

- work has finished and run has been cleared, or
- an error with stop-on-error enabled has been followed by completion of the current descriptor.

Software reads the whole word through a 32-bit read port. It clears flags through a 32-bit write port that uses write-one-to-clear.

A parameter states whether the engine is in a stream-to-memory configuration. In any other configuration the end-of-packet event can never be recorded.

Top module: `sgdma_status_reg`

## Requirements
- R1: After synchronous reset every bit of `rd_data` reads 0.
- R2: A pulse on `ev_err`, `ev_eop`, `ev_desc_done` or `ev_chain_done` sets bit 0, 1, 2 or 3 of `rd_data` respectively, visible after the next rising clock edge. The bit then stays 1 while no clear reaches it.
- R3: A write (`wr_en`=1) with a 1 in bit position 0..3 of `wr_data` clears that flag after the edge. A 0 in a position leaves that flag unchanged.
- R4: When an event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up 1.
- R5: Bits 31..5 of `rd_data` always read 0, whatever value is written to them.
- R6: With `STREAM_TO_MEM`=0, `ev_eop` is ignored and bit 1 always reads 0.
- R7: BUSY (bit 4) becomes 1 after the first clock edge at which `run` is sampled high following a cycle in which it was low.
- R8: Once BUSY is 1 it stays 1 while `run` is high and no stop-on-error halt has happened. This holds across descriptor-done pulses. After `run` drops, BUSY stays 1 until a completion pulse arrives.
- R9: With `run` low, BUSY drops after the edge at which a descriptor-done or chain-done pulse is seen. It also drops if a chain-done pulse was already seen during the current busy period.
- R10: An `ev_err` pulse while BUSY=1 and `stop_on_err`=1 arms a pending stop. The next `ev_desc_done` pulse then drops BUSY even though `run` is still high, and BUSY stays 0 until `run` is low and then rises again. With `stop_on_err`=0 an error does not affect BUSY.
- R11: BUSY is read-only: writing 0 or 1 to bit 4 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run control bit from the control register |
| stop_on_err | input | 1 | Stop-on-error control bit |
| ev_err | input | 1 | Streaming error event pulse |
| ev_eop | input | 1 | End-of-packet termination event pulse |
| ev_desc_done | input | 1 | Descriptor completed event pulse |
| ev_chain_done | input | 1 | Chain completed event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, 1 = clear flag |
| rd_data | output | 32 | Status word |

## Verification
A corrupted sticky flag shows on `rd_data` one edge after the event or clear that should have produced it. The event/clear sweep covers every combination of prior state, new event and write mask, so a wrong set/clear priority is exposed within that one edge. A wrong BUSY state shows on bit 4 at the first edge after a change of `run` or a completion or error pulse. If the stop-pending or chain-finished memory is lost, BUSY reads wrongly at the later descriptor-done pulse or when `run` falls. The engine never sees those internal flags directly.

// File: rtl/sgdma_stat_pkg.sv
package sgdma_stat_pkg;
  localparam int FLAG_ERR   = 0;
  localparam int FLAG_EOP   = 1;
  localparam int FLAG_DESC  = 2;
  localparam int FLAG_CHAIN = 3;
  localparam int FLAG_BUSY  = 4;
  localparam int N_STICKY   = 4;
  localparam int N_USED     = 5;
endpackage

// File: rtl/sgdma_sticky_flag.sv
module sgdma_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_r;

  // set has priority over a same-cycle clear so no event is lost
  always_ff @(posedge clk) begin
    if (rst)        q_r <= 1'b0;
    else if (set_i) q_r <= 1'b1;
    else if (clr_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/sgdma_busy_track.sv
module sgdma_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic stop_on_err,
  input  logic ev_err,
  input  logic ev_desc_done,
  input  logic ev_chain_done,
  output logic busy_o
);
  logic run_q, busy_q, stop_pend_q, chain_fin_q;
  logic rise, err_stop, halt_now, finish_now;

  assign rise       = run & ~run_q;
  assign err_stop   = busy_q & ev_err & stop_on_err;
  assign halt_now   = (stop_pend_q | err_stop) & ev_desc_done;
  assign finish_now = ~run & (chain_fin_q | ev_chain_done | ev_desc_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      busy_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      chain_fin_q <= 1'b0;
    end else begin
      run_q <= run;
      if (rise) begin
        busy_q      <= 1'b1;
        stop_pend_q <= 1'b0;
        chain_fin_q <= 1'b0;
      end else if (busy_q) begin
        if (halt_now || finish_now) begin
          busy_q      <= 1'b0;
          stop_pend_q <= 1'b0;
          chain_fin_q <= 1'b0;
        end else begin
          stop_pend_q <= stop_pend_q | err_stop;
          chain_fin_q <= chain_fin_q | ev_chain_done;
        end
      end
    end
  end

  assign busy_o = busy_q;

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !run_q) |=> busy_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && run && !stop_pend_q && !(ev_err && stop_on_err)) |=> busy_o);

  // R10
  stop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && stop_pend_q && ev_desc_done && !rise) |=> !busy_o);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && run && run_q) |=> !busy_o);
endmodule

// File: rtl/sgdma_status_reg.sv
module sgdma_status_reg #(
  parameter int REG_W         = 32,
  parameter bit STREAM_TO_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             stop_on_err,
  input  logic             ev_err,
  input  logic             ev_eop,
  input  logic             ev_desc_done,
  input  logic             ev_chain_done,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  import sgdma_stat_pkg::*;

  localparam int RSV_W = REG_W - N_USED;

  logic [N_STICKY-1:0] ev_vec, clr_vec, flag_q;
  logic                eop_gated, busy;

  generate
    if (STREAM_TO_MEM) begin : g_eop_on
      assign eop_gated = ev_eop;
    end else begin : g_eop_off
      assign eop_gated = 1'b0;
    end
  endgenerate

  always_comb begin
    ev_vec             = '0;
    ev_vec[FLAG_ERR]   = ev_err;
    ev_vec[FLAG_EOP]   = eop_gated;
    ev_vec[FLAG_DESC]  = ev_desc_done;
    ev_vec[FLAG_CHAIN] = ev_chain_done;
  end

  assign clr_vec = wr_en ? wr_data[N_STICKY-1:0] : '0;

  generate
    for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
      sgdma_sticky_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set_i(ev_vec[i]),
        .clr_i(clr_vec[i]),
        .q_o  (flag_q[i])
      );
    end
  endgenerate

  sgdma_busy_track u_busy (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .stop_on_err  (stop_on_err),
    .ev_err       (ev_err),
    .ev_desc_done (ev_desc_done),
    .ev_chain_done(ev_chain_done),
    .busy_o       (busy)
  );

  assign rd_data = {{RSV_W{1'b0}}, busy, flag_q};

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/sgdma_status_reg_tb.sv
module sgdma_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst, run, stop_on_err;
  logic        ev_err, ev_eop, ev_desc_done, ev_chain_done, wr_en;
  logic [31:0] wr_data, rd_s2m, rd_m2m;
  int          n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  sgdma_status_reg #(.REG_W(32), .STREAM_TO_MEM(1'b1)) dut_i (
    .clk(clk), .rst(rst), .run(run), .stop_on_err(stop_on_err),
    .ev_err(ev_err), .ev_eop(ev_eop), .ev_desc_done(ev_desc_done),
    .ev_chain_done(ev_chain_done), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_s2m));

  sgdma_status_reg #(.REG_W(32), .STREAM_TO_MEM(1'b0)) dut_m2m_i (
    .clk(clk), .rst(rst), .run(run), .stop_on_err(stop_on_err),
    .ev_err(ev_err), .ev_eop(ev_eop), .ev_desc_done(ev_desc_done),
    .ev_chain_done(ev_chain_done), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_m2m));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [3:0] e);
    {ev_chain_done, ev_desc_done, ev_eop, ev_err} = e;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busy_chk(input string tag, input logic exp);
    chk(tag, {31'b0, rd_s2m[4]}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; run = 1'b0; stop_on_err = 1'b0; wr_en = 1'b0; wr_data = '0;
    drive_ev(4'h0);
    @(negedge clk); @(negedge clk);
    // R1: both variants read zero after reset
    chk("R1 s2m", rd_s2m, 32'h0);
    chk("R1 m2m", rd_m2m, 32'h0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6: sweep prior flags x new events x clear mask
    for (int pre = 0; pre < 16; pre++) begin
      for (int ev2 = 0; ev2 < 16; ev2++) begin
        for (int wm = 0; wm < 16; wm++) begin
          logic [3:0] p4, e4, m4, exp_s, exp_m;
          p4 = pre[3:0]; e4 = ev2[3:0]; m4 = wm[3:0];
          drive_ev(p4); wr_en = 1'b0;
          tick();
          chk("R2 preload s2m", rd_s2m, {28'h0, p4});
          chk("R6 preload m2m", rd_m2m, {28'h0, p4 & 4'b1101});
          drive_ev(e4); wr_en = 1'b1;
          wr_data = {27'h7FF_FFFF ^ {23'h0, p4}, 1'b1, m4};
          tick();
          exp_s = e4 | (p4 & ~m4);
          exp_m = exp_s & 4'b1101;
          chk("R3/R4/R5/R11 s2m", rd_s2m, {28'h0, exp_s});
          chk("R4/R6 m2m", rd_m2m, {28'h0, exp_m});
          drive_ev(4'h0); wr_data = 32'hFFFF_FFEF;
          tick();
          chk("R3 clear-all", rd_s2m, 32'h0);
          wr_en = 1'b0;
        end
      end
    end

    // R7 R8 R9 R11: normal run, descriptor done then run drop
    wr_data = 32'h0;
    busy_chk("R7 idle", 1'b0);
    run = 1'b1;
    tick();
    busy_chk("R7 rise", 1'b1);
    wr_en = 1'b1; wr_data = 32'h0000_0010;
    tick();
    busy_chk("R11 write one", 1'b1);
    wr_data = 32'h0;
    tick();
    busy_chk("R11 write zero", 1'b1);
    wr_en = 1'b0;
    drive_ev(4'b0100);
    tick();
    busy_chk("R8 desc done run high", 1'b1);
    drive_ev(4'h0); run = 1'b0;
    tick();
    busy_chk("R8 run low pending", 1'b1);
    tick();
    busy_chk("R8 still pending", 1'b1);
    drive_ev(4'b0100);
    tick();
    busy_chk("R9 desc done run low", 1'b0);
    drive_ev(4'h0);

    // R9: chain done seen while run high, then run drops
    run = 1'b1;
    tick();
    busy_chk("R7 second rise", 1'b1);
    drive_ev(4'b1000);
    tick();
    busy_chk("R8 chain done run high", 1'b1);
    drive_ev(4'h0); run = 1'b0;
    tick();
    busy_chk("R9 chain remembered", 1'b0);

    // R10: error with stop enabled
    stop_on_err = 1'b1; run = 1'b1;
    tick();
    busy_chk("R7 third rise", 1'b1);
    drive_ev(4'b0001);
    tick();
    busy_chk("R10 error armed", 1'b1);
    drive_ev(4'h0);
    tick();
    busy_chk("R10 still busy", 1'b1);
    drive_ev(4'b0100);
    tick();
    busy_chk("R10 halt on desc done", 1'b0);
    drive_ev(4'h0);
    tick();
    busy_chk("R10 no restart run high", 1'b0);
    run = 1'b0;
    tick();
    run = 1'b1;
    tick();
    busy_chk("R10 restart after rise", 1'b1);

    // R10: error without stop-on-error leaves BUSY up
    run = 1'b0; drive_ev(4'b0100);
    tick();
    drive_ev(4'h0); stop_on_err = 1'b0; run = 1'b1;
    tick();
    drive_ev(4'b0001);
    tick();
    drive_ev(4'b0100);
    tick();
    busy_chk("R10 no stop keeps busy", 1'b1);
    drive_ev(4'h0); run = 1'b0;
    tick();
    drive_ev(4'b0100);
    tick();
    busy_chk("R9 final drop", 1'b0);
    drive_ev(4'h0);

    // R1: reset mid-activity
    run = 1'b1; drive_ev(4'b1111);
    tick();
    rst = 1'b1; drive_ev(4'h0);
    tick();
    chk("R1 reset again", rd_s2m, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule